// File: doc/BRIEF.md
# Clock Loss-of-Lock Monitor

This block compares a recovered receive clock with a reference clock and reports when their rates have drifted too far apart. It works in the domain of a fast local sampling clock. All incoming clocks must be slower than half the sampling rate. Each incoming clock passes through a two-flop synchronizer and then an edge detector.

Over a window of `WIN_LEN` reference rising edges, the block counts the rising edges of the recovered clock. At the end of each window it takes the absolute difference between that count and `WIN_LEN`. Two thresholds give hysteresis:
- Above `SET_THR`, the block reports loss of lock.
- Below `CLR_THR`, it reports lock.
- Between the two, the previous state is kept.

With the default window of 65536, the thresholds of 518 and 505 correspond to about 7900 ppm and 7700 ppm.

The reference is chosen from three master clock inputs according to the configured line rate. When none of the three is toggling, the transmit clock is used instead. When no usable reference exists, the measurement stops and loss of lock cannot be raised. Every change of the status bit latches an event flag, which software clears by writing one to it. The event flag drives an interrupt output when the enable bit is high.

Top module: `lol_monitor`

## Requirements
- R1: After reset, `lol`, `lol_evt` and `irq` are 0.
- R2: At the end of a window of `WIN_LEN` reference rising edges, `lol` becomes 1 if the absolute difference between the recovered edge count and `WIN_LEN` exceeds `SET_THR`.
- R3: At the end of a window, `lol` becomes 0 only if that difference is below `CLR_THR`. A difference from `CLR_THR` to `SET_THR` inclusive leaves `lol` unchanged.
- R4: `lol` changes only at the end of a complete window. A window begins only after reset or after a change of reference source.
- R5: The master reference is selected by `rate_sel`: 0 selects `mclk_a`, 1 selects `mclk_b`, and 2 or 3 select `mclk_c`. If the selected master is idle while another master is active, there is no usable reference.
- R6: When none of the three masters has toggled within the last `IDLE_LIMIT` sampling cycles, `tx_clk` becomes the reference.
- R7: When no master is active and `tx_clk` is idle (low or stuck high), `lol` does not rise, whatever the recovered clock does.
- R8: Every transition of `lol`, in either direction, sets `lol_evt` on the following cycle.
- R9: A one-cycle pulse on `evt_clr` clears `lol_evt`. If a new transition lands in the same cycle as the pulse, `lol_evt` stays 1.
- R10: `irq` is 1 exactly when `lol_evt` is 1 and `irq_en` was 1 at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Line-rate selector: picks the master reference input |
| mclk_a | input | 1 | Master clock for rate 0 |
| mclk_b | input | 1 | Master clock for rate 1 |
| mclk_c | input | 1 | Master clock for rates 2 and 3 |
| tx_clk | input | 1 | Transmit clock, used as the fallback reference |
| rx_clk | input | 1 | Recovered receive clock being monitored |
| irq_en | input | 1 | Interrupt enable |
| evt_clr | input | 1 | Write-one-to-clear pulse for the event flag |
| lol | output | 1 | Loss-of-lock status |
| lol_evt | output | 1 | Latched change-of-state flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- Every monitored clock holds each level for at least one sampling cycle, so the synchronizers see every toggle.
- `rate_sel` stays steady within a measurement window.

The bench builds every clock inside the sampling domain and changes its level only at falling edges of `clk`:
- The reference is a square wave with a period of four cycles.
- The recovered clock comes from a phase accumulator that toggles at most once per cycle.
- `rate_sel` and the clock enables change only between test phases, never in the middle of a phase.

Status checks are made at least two full windows after each change of rate.

// File: rtl/lol_pkg.sv
package lol_pkg;
  typedef enum logic [2:0] {
    SRC_A    = 3'd0,
    SRC_B    = 3'd1,
    SRC_C    = 3'd2,
    SRC_TX   = 3'd3,
    SRC_NONE = 3'd4
  } ref_src_e;
endpackage

// File: rtl/lol_clk_probe.sv
// Synchronizes one slow clock into the sampling domain, gives a rising-edge
// strobe and an activity flag that drops after IDLE_LIMIT quiet cycles.
module lol_clk_probe #(
  parameter int IDLE_LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_in,
  output logic rise,
  output logic active
);
  localparam int IW = $clog2(IDLE_LIMIT + 1);
  localparam logic [IW-1:0] IDLE_V = IW'(IDLE_LIMIT);

  logic          s1, s2, s3;
  logic [IW-1:0] idle_cnt;
  logic          toggle;

  assign toggle = s2 ^ s3;
  assign rise   = s2 & ~s3;
  assign active = (idle_cnt != IDLE_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1       <= 1'b0;
      s2       <= 1'b0;
      s3       <= 1'b0;
      idle_cnt <= IDLE_V;
    end else begin
      s1 <= clk_in;
      s2 <= s1;
      s3 <= s2;
      if (toggle)
        idle_cnt <= '0;
      else if (idle_cnt != IDLE_V)
        idle_cnt <= idle_cnt + 1'b1;
    end
  end

  // R6: a clock becomes active only after a toggle was seen
  assert_active_needs_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(toggle));
  // R7: activity is lost only after a quiet cycle
  assert_idle_needs_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> $past(!toggle));
endmodule

// File: rtl/lol_ref_select.sv
// Picks the reference edge stream: selected master, transmit fallback, or none.
module lol_ref_select
  import lol_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate_sel,
  input  logic [2:0] m_act,
  input  logic [2:0] m_rise,
  input  logic       tx_act,
  input  logic       tx_rise,
  output logic       ref_rise,
  output logic       ref_ok,
  output logic       restart
);
  ref_src_e src, src_q;

  always_comb begin
    src = SRC_NONE;
    if (m_act == 3'b000) begin
      if (tx_act) src = SRC_TX;
    end else begin
      unique case (rate_sel)
        2'd0:    if (m_act[0]) src = SRC_A;
        2'd1:    if (m_act[1]) src = SRC_B;
        default: if (m_act[2]) src = SRC_C;
      endcase
    end
  end

  always_comb begin
    unique case (src)
      SRC_A:   ref_rise = m_rise[0];
      SRC_B:   ref_rise = m_rise[1];
      SRC_C:   ref_rise = m_rise[2];
      SRC_TX:  ref_rise = tx_rise;
      default: ref_rise = 1'b0;
    endcase
  end

  assign ref_ok  = (src != SRC_NONE);
  assign restart = (src != src_q);

  always_ff @(posedge clk) begin
    if (rst) src_q <= SRC_NONE;
    else     src_q <= src;
  end
endmodule

// File: rtl/lol_freq_meter.sv
// Counts recovered edges per window of reference edges and applies the
// hysteresis comparison.
module lol_freq_meter #(
  parameter int WIN_LEN = 65536,
  parameter int SET_THR = 518,
  parameter int CLR_THR = 505
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_rise,
  input  logic ref_ok,
  input  logic restart,
  input  logic rec_rise,
  output logic lol,
  output logic lol_chg
);
  localparam int WW = $clog2(WIN_LEN);
  localparam int CW = WW + 2;
  localparam int EW = CW + 1;
  localparam logic [WW-1:0] LAST_V = WW'(WIN_LEN - 1);
  localparam logic [EW-1:0] WIN_V  = EW'(WIN_LEN);
  localparam logic [EW-1:0] SET_V  = EW'(SET_THR);
  localparam logic [EW-1:0] CLR_V  = EW'(CLR_THR);
  localparam logic [CW-1:0] REC_MAX = '1;

  logic [WW-1:0] ref_cnt;
  logic [CW-1:0] rec_cnt;
  logic [EW-1:0] rec_tot, err;
  logic          win_end;

  assign win_end = ref_ok && !restart && ref_rise && (ref_cnt == LAST_V);
  assign rec_tot = {1'b0, rec_cnt} + EW'(rec_rise);
  assign err     = (rec_tot >= WIN_V) ? (rec_tot - WIN_V) : (WIN_V - rec_tot);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_cnt <= '0;
      rec_cnt <= '0;
      lol     <= 1'b0;
      lol_chg <= 1'b0;
    end else begin
      lol_chg <= 1'b0;
      if (!ref_ok || restart) begin
        ref_cnt <= '0;
        rec_cnt <= '0;
      end else if (win_end) begin
        ref_cnt <= '0;
        rec_cnt <= '0;
        if (!lol && err > SET_V) begin
          lol     <= 1'b1;
          lol_chg <= 1'b1;
        end else if (lol && err < CLR_V) begin
          lol     <= 1'b0;
          lol_chg <= 1'b1;
        end
      end else begin
        if (ref_rise) ref_cnt <= ref_cnt + 1'b1;
        if (rec_rise && rec_cnt != REC_MAX) rec_cnt <= rec_cnt + 1'b1;
      end
    end
  end

  // R4: status only moves at a completed window
  assert_change_at_window_R4: assert property (@(posedge clk) disable iff (rst)
    (lol != $past(lol)) |-> $past(win_end));
  // R7: no rise without a usable reference
  assert_rise_needs_ref_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(lol) |-> $past(ref_ok));
endmodule

// File: rtl/lol_event.sv
// Latched change-of-state flag with write-one-to-clear and gated interrupt.
module lol_event (
  input  logic clk,
  input  logic rst,
  input  logic lol_chg,
  input  logic evt_clr,
  input  logic irq_en,
  output logic evt,
  output logic irq
);
  logic evt_nx;

  always_comb begin
    evt_nx = evt;
    if (evt_clr) evt_nx = 1'b0;
    if (lol_chg) evt_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt <= 1'b0;
      irq <= 1'b0;
    end else begin
      evt <= evt_nx;
      irq <= evt_nx & irq_en;
    end
  end

  // R8: every transition latches the flag
  assert_change_sets_flag_R8: assert property (@(posedge clk) disable iff (rst)
    lol_chg |=> evt);
  // R9: a clear without a simultaneous transition empties the flag
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (rst)
    (evt_clr && !lol_chg) |=> !evt);
  // R10: interrupt only with the enable set and the flag raised
  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(irq_en) && evt));
endmodule

// File: rtl/lol_monitor.sv
module lol_monitor #(
  parameter int WIN_LEN    = 65536,
  parameter int SET_THR    = 518,
  parameter int CLR_THR    = 505,
  parameter int IDLE_LIMIT = 64,
  parameter int N_MASTER   = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate_sel,
  input  logic       mclk_a,
  input  logic       mclk_b,
  input  logic       mclk_c,
  input  logic       tx_clk,
  input  logic       rx_clk,
  input  logic       irq_en,
  input  logic       evt_clr,
  output logic       lol,
  output logic       lol_evt,
  output logic       irq
);
  logic [N_MASTER-1:0] m_in, m_act, m_rise;
  logic tx_act, tx_rise, rx_act, rx_rise;
  logic ref_rise, ref_ok, restart, lol_chg;

  assign m_in = {mclk_c, mclk_b, mclk_a};

  for (genvar g = 0; g < N_MASTER; g++) begin : g_master
    lol_clk_probe #(.IDLE_LIMIT(IDLE_LIMIT)) i_probe (
      .clk(clk), .rst(rst), .clk_in(m_in[g]),
      .rise(m_rise[g]), .active(m_act[g]));
  end

  lol_clk_probe #(.IDLE_LIMIT(IDLE_LIMIT)) i_tx_probe (
    .clk(clk), .rst(rst), .clk_in(tx_clk), .rise(tx_rise), .active(tx_act));

  lol_clk_probe #(.IDLE_LIMIT(IDLE_LIMIT)) i_rx_probe (
    .clk(clk), .rst(rst), .clk_in(rx_clk), .rise(rx_rise), .active(rx_act));

  lol_ref_select i_sel (
    .clk(clk), .rst(rst), .rate_sel(rate_sel),
    .m_act(m_act), .m_rise(m_rise), .tx_act(tx_act), .tx_rise(tx_rise),
    .ref_rise(ref_rise), .ref_ok(ref_ok), .restart(restart));

  lol_freq_meter #(.WIN_LEN(WIN_LEN), .SET_THR(SET_THR), .CLR_THR(CLR_THR)) i_meter (
    .clk(clk), .rst(rst), .ref_rise(ref_rise), .ref_ok(ref_ok),
    .restart(restart), .rec_rise(rx_rise), .lol(lol), .lol_chg(lol_chg));

  lol_event i_evt (
    .clk(clk), .rst(rst), .lol_chg(lol_chg), .evt_clr(evt_clr),
    .irq_en(irq_en), .evt(lol_evt), .irq(irq));

  // R5/R6: the transmit fallback never coexists with an active master edge stream
  assert_ref_stream_R6: assert property (@(posedge clk) disable iff (rst)
    (ref_rise && m_act == '0) |-> tx_act);
  // R7: recovered-clock activity has no bearing on a missing reference
  assert_no_ref_no_rise_R7: assert property (@(posedge clk) disable iff (rst)
    (!ref_ok && rx_act) |=> !$rose(lol));
endmodule

// File: tb/test_lol_monitor.sv
module test_lol_monitor;
  localparam int WIN = 1024;
  localparam int WCLK = WIN * 4;
  localparam int SETTLE = 9000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] rate_sel = 2'd0;
  logic mclk_a = 1'b0, mclk_b = 1'b0, mclk_c = 1'b0, tx_clk = 1'b0, rx_clk = 1'b0;
  logic irq_en = 1'b1, evt_clr = 1'b0;
  logic lol, lol_evt, irq;

  logic [2:0] m_run = 3'b001;
  logic       m_lvl = 1'b0;
  logic       tx_run = 1'b1;
  int         rec_step = 2 * WIN;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  lol_monitor #(.WIN_LEN(WIN), .SET_THR(24), .CLR_THR(8), .IDLE_LIMIT(64)) i_lol_monitor (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .mclk_a(mclk_a), .mclk_b(mclk_b),
    .mclk_c(mclk_c), .tx_clk(tx_clk), .rx_clk(rx_clk), .irq_en(irq_en),
    .evt_clr(evt_clr), .lol(lol), .lol_evt(lol_evt), .irq(irq));

  initial begin : gen
    int ph;
    int acc;
    logic w;
    ph = 0;
    acc = 0;
    forever begin
      @(negedge clk);
      ph = ph + 1;
      w = ph[1];
      mclk_a = m_run[0] ? w : m_lvl;
      mclk_b = m_run[1] ? w : m_lvl;
      mclk_c = m_run[2] ? w : m_lvl;
      tx_clk = tx_run ? w : 1'b0;
      acc = acc + rec_step;
      if (acc >= WCLK) begin
        acc = acc - WCLK;
        rx_clk = ~rx_clk;
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    evt_clr = 1'b1;
    @(negedge clk);
    evt_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    wait_clk(4);
    chk("R1 lol", lol, 1'b0);
    chk("R1 evt", lol_evt, 1'b0);
    chk("R1 irq", irq, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_first_window();
    rec_step = 2 * (WIN + 40);
    wait_clk(WCLK / 2);
    chk("R4 no early decision", lol, 1'b0);
    wait_clk(SETTLE);
    chk("R2 fast rx sets lol", lol, 1'b1);
    chk("R8 rise sets evt", lol_evt, 1'b1);
    chk("R10 irq enabled", irq, 1'b1);
  endtask

  task automatic t_hold();
    pulse_clr();
    chk("R9 clear", lol_evt, 1'b0);
    chk("R10 irq follows evt", irq, 1'b0);
    rec_step = 2 * (WIN + 16);
    wait_clk(SETTLE);
    chk("R3 hold band keeps lol", lol, 1'b1);
    chk("R3 no change no evt", lol_evt, 1'b0);
  endtask

  task automatic t_clear_collide();
    rec_step = 2 * WIN;
    for (int i = 0; i < 3 * WCLK && lol !== 1'b0; i++) @(negedge clk);
    chk("R3 exact rx clears lol", lol, 1'b0);
    evt_clr = 1'b1;
    @(negedge clk);
    evt_clr = 1'b0;
    chk("R9 set wins over clear", lol_evt, 1'b1);
    pulse_clr();
    chk("R9 later clear", lol_evt, 1'b0);
  endtask

  task automatic t_irq_mask();
    irq_en = 1'b0;
    rec_step = 2 * (WIN - 40);
    wait_clk(SETTLE);
    chk("R2 slow rx sets lol", lol, 1'b1);
    chk("R8 evt set", lol_evt, 1'b1);
    chk("R10 irq masked", irq, 1'b0);
    irq_en = 1'b1;
    wait_clk(2);
    chk("R10 irq unmasked", irq, 1'b1);
    pulse_clr();
    rec_step = 2 * WIN;
    wait_clk(SETTLE);
    chk("R3 back to lock", lol, 1'b0);
    chk("R8 fall sets evt", lol_evt, 1'b1);
    pulse_clr();
  endtask

  task automatic t_no_ref();
    m_run = 3'b000;
    m_lvl = 1'b1;
    tx_run = 1'b0;
    rec_step = 2 * (WIN + 40);
    wait_clk(SETTLE);
    chk("R7 no ref no lol", lol, 1'b0);
    chk("R7 no ref no evt", lol_evt, 1'b0);
  endtask

  task automatic t_tx_fallback();
    tx_run = 1'b1;
    wait_clk(SETTLE);
    chk("R6 tx fallback sets lol", lol, 1'b1);
    rec_step = 2 * WIN;
    wait_clk(SETTLE);
    chk("R6 tx fallback clears lol", lol, 1'b0);
    pulse_clr();
  endtask

  task automatic t_rate_sel();
    m_lvl = 1'b0;
    m_run = 3'b010;
    rate_sel = 2'd0;
    rec_step = 2 * (WIN + 40);
    wait_clk(SETTLE);
    chk("R5 idle selected master", lol, 1'b0);
    rate_sel = 2'd1;
    wait_clk(SETTLE);
    chk("R5 rate 1 uses mclk_b", lol, 1'b1);
  endtask

  initial begin
    t_reset();
    t_first_window();
    t_hold();
    t_clear_collide();
    t_irq_mask();
    t_no_ref();
    t_tx_fallback();
    t_rate_sel();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule